// File: doc/BRIEF.md
# Outbound Access Error Capture Unit

This block sits beside a host bridge and keeps a record of the first outbound configuration or memory access that fails. A detector elsewhere pulses a one-cycle error strobe. With the strobe it presents the class of the access (configuration or memory), its width, its direction, its byte-lane enables, the target (bus/device/function/register for configuration, a 64-bit address for memory) and a raw seven-bit cause vector. If capture is enabled for that class and no record is held, the unit latches the record and raises `err_pending`.

Software reads the record through a flat 32-bit register port and then discards it by writing 1 to the discard register. Configuration and memory failures keep separate target and cause registers. The fields of the class that did not fail read zero, and cause bits that the class does not define are dropped. Read data is combinational on `reg_addr`.

Top module: `oberr_capture`

## Requirements
- R1: Reset (synchronous, active low) clears the record, the enable register and `err_pending`. Every mapped offset then reads 0.
- R2: Offset 0x08 is the enable register. Bits 1:0 are writable and read back, and all other bits read 0. Bit 0 enables capture of configuration errors and bit 1 enables capture of memory errors. A write changes the enables from the next cycle on.
- R3: A strobe whose class (`err_class` 0 = configuration, 1 = memory) has its enable bit at 0 is ignored. `err_pending` stays low and the record stays zero.
- R4: A captured configuration error reads back as follows. Offset 0x0C holds the attribute word: bit 0 = 1, bit 2 = wide (64-bit), bit 4 = write, bits 15:8 = lanes. Offset 0x18 holds bus in 27:20, device in 19:15, function in 14:12 and register in 11:0. Offset 0x14 holds the cause bits 6,5,4,2,1,0 (mask 0x77). Offsets 0x10, 0x20 and 0x24 read 0.
- R5: A captured memory error reads back as follows. Offset 0x0C holds bit 1 = 1 together with the same width, direction and lane fields as in R4. Offset 0x20 holds address bits 31:0 and offset 0x24 holds address bits 63:32. Offset 0x10 holds the cause bits 6,5,4,1,0 (mask 0x73). Offsets 0x14 and 0x18 read 0.
- R6: In the cycle after an accepted strobe, `err_pending` is 1 and offset 0x00 reads 1.
- R7: While a record is held, later strobes leave it unchanged.
- R8: A write to offset 0x04 with data bit 0 set clears the record and `err_pending` in the next cycle. A write with bit 0 clear has no effect.
- R9: When a discard write and an accepted strobe fall in the same cycle, the new access is captured and `err_pending` stays 1.
- R10: Unmapped offsets, unaligned offsets and the discard offset read 0.
- R11: Writes to the record offsets (0x00, 0x0C, 0x10, 0x14, 0x18, 0x20, 0x24) do not change the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_strobe | input | 1 | One-cycle pulse marking a failed access |
| err_class | input | 1 | 0 = configuration access, 1 = memory access |
| err_wide | input | 1 | Access was 64-bit |
| err_write | input | 1 | Access was a write (0 = read) |
| err_lanes | input | LANES | Byte-lane enables of the access |
| err_bus | input | 8 | Configuration target bus |
| err_dev | input | 5 | Configuration target device |
| err_fn | input | 3 | Configuration target function |
| err_reg | input | 12 | Configuration register offset |
| err_maddr | input | MADDR_W | Memory target address |
| err_cause | input | 7 | Raw cause vector from the detector |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| err_pending | output | 1 | A record is held |

## Verification
The capture of a new error and the software discard can fall in the same clock edge. The bench provokes this by driving a discard write and an enabled strobe in the same cycle while a different record is already held. It then checks that `err_pending` stays high and that the attribute and target registers show the new access rather than the old one or zeros. A discard write with bit 0 clear, a second strobe while a record is held, and a strobe of a disabled class are each driven and checked at the register port.

// File: rtl/oberr_pkg.sv
// Shared constants for the outbound error capture unit: register byte
// offsets, attribute-word bit positions and the per-class cause masks.
// Assumes a 32-bit register port and byte offsets that fit in 8 bits.
package oberr_pkg;
    localparam int REG_W = 32;

    localparam logic [7:0] OFS_STATUS   = 8'h00;
    localparam logic [7:0] OFS_DISCARD  = 8'h04;
    localparam logic [7:0] OFS_ENABLE   = 8'h08;
    localparam logic [7:0] OFS_ATTR     = 8'h0C;
    localparam logic [7:0] OFS_MCAUSE   = 8'h10;
    localparam logic [7:0] OFS_CCAUSE   = 8'h14;
    localparam logic [7:0] OFS_CTARGET  = 8'h18;
    localparam logic [7:0] OFS_MADDR_LO = 8'h20;
    localparam logic [7:0] OFS_MADDR_HI = 8'h24;

    localparam int ATTR_CFG_BIT  = 0;
    localparam int ATTR_MEM_BIT  = 1;
    localparam int ATTR_WIDE_BIT = 2;
    localparam int ATTR_WR_BIT   = 4;
    localparam int ATTR_LANE_LO  = 8;

    localparam int CAUSE_W = 7;
    localparam logic [CAUSE_W-1:0] CFG_CAUSE_KEEP = 7'h77;
    localparam logic [CAUSE_W-1:0] MEM_CAUSE_KEEP = 7'h73;

    localparam int EN_CFG_BIT = 0;
    localparam int EN_MEM_BIT = 1;
    localparam int EN_W       = 2;

    typedef enum logic {
        CLS_CFG = 1'b0,
        CLS_MEM = 1'b1
    } err_class_e;
endpackage

// File: rtl/oberr_enable_reg.sv
// Capture-enable register: one bit per error class, written through the
// register port. Assumes the caller has already decoded the offset.
module oberr_enable_reg
    import oberr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_wr,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] en_q
);
    // Holds the per-class enables; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (sel_wr) begin
            en_q <= wdata;
        end
    end
endmodule

// File: rtl/oberr_record.sv
// Latched error record. It takes a new record when the strobe's class is
// enabled and either nothing is held or a discard arrives in the same
// cycle. Fields of the other class are zeroed, and undefined cause bits
// are masked off. Assumes the strobe is a single-cycle pulse.
module oberr_record
    import oberr_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int MADDR_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               discard,
    input  logic               strobe,
    input  logic               cls,
    input  logic [EN_W-1:0]    en,
    input  logic               wide,
    input  logic               write,
    input  logic [LANES-1:0]   lanes,
    input  logic [7:0]         bus,
    input  logic [4:0]         dev,
    input  logic [2:0]         fn,
    input  logic [11:0]        regofs,
    input  logic [MADDR_W-1:0] maddr,
    input  logic [CAUSE_W-1:0] cause,
    output logic               valid_q,
    output logic [REG_W-1:0]   attr_q,
    output logic [REG_W-1:0]   ctarget_q,
    output logic [CAUSE_W-1:0] ccause_q,
    output logic [CAUSE_W-1:0] mcause_q,
    output logic [MADDR_W-1:0] maddr_q
);
    logic             is_mem;
    logic             accept;
    logic             take;
    logic [REG_W-1:0] attr_d;
    logic [REG_W-1:0] ctarget_d;

    // Decides whether this cycle's strobe is recorded.
    always_comb begin
        is_mem = (cls == CLS_MEM);
        accept = strobe && (is_mem ? en[EN_MEM_BIT] : en[EN_CFG_BIT]);
        take   = accept && (!valid_q || discard);
    end

    // Builds the attribute word and the packed configuration target.
    always_comb begin
        attr_d = REG_W'(lanes) << ATTR_LANE_LO;
        attr_d[ATTR_CFG_BIT]  = !is_mem;
        attr_d[ATTR_MEM_BIT]  = is_mem;
        attr_d[ATTR_WIDE_BIT] = wide;
        attr_d[ATTR_WR_BIT]   = write;
        ctarget_d = {4'b0, bus, dev, fn, regofs};
    end

    // Record storage: capture beats discard, discard empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            attr_q    <= '0;
            ctarget_q <= '0;
            ccause_q  <= '0;
            mcause_q  <= '0;
            maddr_q   <= '0;
        end else if (take) begin
            valid_q   <= 1'b1;
            attr_q    <= attr_d;
            ctarget_q <= is_mem ? '0 : ctarget_d;
            ccause_q  <= is_mem ? '0 : (cause & CFG_CAUSE_KEEP);
            mcause_q  <= is_mem ? (cause & MEM_CAUSE_KEEP) : '0;
            maddr_q   <= is_mem ? maddr : '0;
        end else if (discard) begin
            valid_q   <= 1'b0;
            attr_q    <= '0;
            ctarget_q <= '0;
            ccause_q  <= '0;
            mcause_q  <= '0;
            maddr_q   <= '0;
        end
    end
endmodule

// File: rtl/oberr_rdmux.sv
// Combinational register read decoder. Unmapped, unaligned and
// write-only offsets return zero. Assumes ADDR_W >= 8.
module oberr_rdmux
    import oberr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               valid,
    input  logic [EN_W-1:0]    en,
    input  logic [REG_W-1:0]   attr,
    input  logic [REG_W-1:0]   ctarget,
    input  logic [CAUSE_W-1:0] ccause,
    input  logic [CAUSE_W-1:0] mcause,
    input  logic [63:0]        maddr,
    output logic [REG_W-1:0]   rdata
);
    // Selects the register addressed by the port.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_STATUS):   rdata = REG_W'(valid);
            ADDR_W'(OFS_ENABLE):   rdata = REG_W'(en);
            ADDR_W'(OFS_ATTR):     rdata = attr;
            ADDR_W'(OFS_MCAUSE):   rdata = REG_W'(mcause);
            ADDR_W'(OFS_CCAUSE):   rdata = REG_W'(ccause);
            ADDR_W'(OFS_CTARGET):  rdata = ctarget;
            ADDR_W'(OFS_MADDR_LO): rdata = maddr[31:0];
            ADDR_W'(OFS_MADDR_HI): rdata = maddr[63:32];
            default:               rdata = '0;
        endcase
    end
endmodule

// File: rtl/oberr_capture.sv
// Outbound access error capture unit (top). It latches the first enabled
// failed access and exposes it through a 32-bit register port until
// software discards it. Assumes MADDR_W <= 64, LANES <= 24 and ADDR_W >= 8.
module oberr_capture
    import oberr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 8,
    parameter int MADDR_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_strobe,
    input  logic               err_class,
    input  logic               err_wide,
    input  logic               err_write,
    input  logic [LANES-1:0]   err_lanes,
    input  logic [7:0]         err_bus,
    input  logic [4:0]         err_dev,
    input  logic [2:0]         err_fn,
    input  logic [11:0]        err_reg,
    input  logic [MADDR_W-1:0] err_maddr,
    input  logic [CAUSE_W-1:0] err_cause,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               err_pending
);
    localparam int MADDR_PAD = 64;

    logic               en_wr;
    logic               discard;
    logic [EN_W-1:0]    enable_q;
    logic               rec_valid;
    logic [REG_W-1:0]   rec_attr;
    logic [REG_W-1:0]   rec_ctarget;
    logic [CAUSE_W-1:0] rec_ccause;
    logic [CAUSE_W-1:0] rec_mcause;
    logic [MADDR_W-1:0] rec_maddr;
    logic [63:0]        maddr_ext;
    logic               unused_wdata;

    // Decodes the register writes that have a side effect.
    always_comb begin
        en_wr        = reg_wr && (reg_addr == ADDR_W'(OFS_ENABLE));
        discard      = reg_wr && (reg_addr == ADDR_W'(OFS_DISCARD)) && reg_wdata[0];
        maddr_ext    = MADDR_PAD'(rec_maddr);
        unused_wdata = ^reg_wdata[REG_W-1:EN_W];
    end

    oberr_enable_reg u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_wr (en_wr),
        .wdata  (reg_wdata[EN_W-1:0]),
        .en_q   (enable_q)
    );

    oberr_record #(
        .LANES   (LANES),
        .MADDR_W (MADDR_W)
    ) u_record (
        .clk       (clk),
        .rst_n     (rst_n),
        .discard   (discard),
        .strobe    (err_strobe),
        .cls       (err_class),
        .en        (enable_q),
        .wide      (err_wide),
        .write     (err_write),
        .lanes     (err_lanes),
        .bus       (err_bus),
        .dev       (err_dev),
        .fn        (err_fn),
        .regofs    (err_reg),
        .maddr     (err_maddr),
        .cause     (err_cause),
        .valid_q   (rec_valid),
        .attr_q    (rec_attr),
        .ctarget_q (rec_ctarget),
        .ccause_q  (rec_ccause),
        .mcause_q  (rec_mcause),
        .maddr_q   (rec_maddr)
    );

    oberr_rdmux #(
        .ADDR_W (ADDR_W)
    ) u_rdmux (
        .addr    (reg_addr),
        .valid   (rec_valid),
        .en      (enable_q),
        .attr    (rec_attr),
        .ctarget (rec_ctarget),
        .ccause  (rec_ccause),
        .mcause  (rec_mcause),
        .maddr   (maddr_ext),
        .rdata   (reg_rdata)
    );

    assign err_pending = rec_valid;
endmodule

// File: rtl/oberr_capture_chk.sv
// Assertion checker for oberr_capture, attached by bind. It observes the
// port behaviour around capture, hold and discard.
module oberr_capture_chk
    import oberr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_pending,
    input logic              err_strobe,
    input logic              err_class,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wbit0,
    input logic [EN_W-1:0]   enables,
    input logic [REG_W-1:0]  attr
);
    logic clr;
    logic hit;

    // Recomputes the discard request and an enabled strobe from the ports.
    always_comb begin
        clr = reg_wr && (reg_addr == ADDR_W'(OFS_DISCARD)) && wbit0;
        hit = err_strobe && (err_class ? enables[EN_MEM_BIT] : enables[EN_CFG_BIT]);
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !err_pending);

    a_r3_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_pending && !hit) |=> !err_pending);

    a_r6_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_pending && hit) |=> err_pending);

    a_r7_first_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pending && !clr) |=> (err_pending && $stable(attr)));

    a_r8_discard_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !err_pending);

    a_r9_clear_then_take: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit) |=> err_pending);
endmodule

bind oberr_capture oberr_capture_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_pending (err_pending),
    .err_strobe  (err_strobe),
    .err_class   (err_class),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .wbit0       (reg_wdata[0]),
    .enables     (enable_q),
    .attr        (rec_attr)
);

// File: tb/tb_oberr_capture.sv
module tb_oberr_capture;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic        cls;
        logic        wide;
        logic        wr;
        logic [7:0]  lanes;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] rg;
        logic [63:0] ma;
        logic [6:0]  cause;
        logic [31:0] x_attr;
        logic [31:0] x_ctgt;
        logic [31:0] x_ccause;
        logic [31:0] x_mlo;
        logic [31:0] x_mhi;
        logic [31:0] x_mcause;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{1'b0, 1'b0, 1'b0, 8'h0F, 8'h12, 5'h05, 3'h3, 12'h0A4, 64'hDEADBEEF_00001111, 7'h7F,
          32'h0000_0F01, 32'h0122_B0A4, 32'h77, 32'h0, 32'h0, 32'h0},
        '{1'b1, 1'b1, 1'b1, 8'hF0, 8'h33, 5'h01, 3'h1, 12'h010, 64'h00000012_38000000, 7'h7F,
          32'h0000_F016, 32'h0, 32'h0, 32'h3800_0000, 32'h0000_0012, 32'h73},
        '{1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 5'h1F, 3'h7, 12'hFFF, 64'h0, 7'h08,
          32'h0000_FF15, 32'h0FFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0},
        '{1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 5'h00, 3'h0, 12'h000, 64'hFFFFFFFF_00000004, 7'h0C,
          32'h0000_0102, 32'h0, 32'h0, 32'h0000_0004, 32'hFFFF_FFFF, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_strobe = 1'b0;
    logic        err_class = 1'b0;
    logic        err_wide = 1'b0;
    logic        err_write = 1'b0;
    logic [7:0]  err_lanes = '0;
    logic [7:0]  err_bus = '0;
    logic [4:0]  err_dev = '0;
    logic [2:0]  err_fn = '0;
    logic [11:0] err_reg = '0;
    logic [63:0] err_maddr = '0;
    logic [6:0]  err_cause = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_pending;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    oberr_capture dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_strobe  (err_strobe),
        .err_class   (err_class),
        .err_wide    (err_wide),
        .err_write   (err_write),
        .err_lanes   (err_lanes),
        .err_bus     (err_bus),
        .err_dev     (err_dev),
        .err_fn      (err_fn),
        .err_reg     (err_reg),
        .err_maddr   (err_maddr),
        .err_cause   (err_cause),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .err_pending (err_pending)
    );

    task automatic put_err(input vec_t v);
        err_class = v.cls;
        err_wide  = v.wide;
        err_write = v.wr;
        err_lanes = v.lanes;
        err_bus   = v.bus;
        err_dev   = v.dev;
        err_fn    = v.fn;
        err_reg   = v.rg;
        err_maddr = v.ma;
        err_cause = v.cause;
        err_strobe = 1'b1;
    endtask

    task automatic strobe(input vec_t v);
        @(negedge clk);
        put_err(v);
        @(negedge clk);
        err_strobe = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clr_and_strobe(input vec_t v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h1;
        put_err(v);
        @(negedge clk);
        reg_wr = 1'b0; err_strobe = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s offset=0x%02h actual=0x%08h expected=0x%08h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic pend(input logic exp, input string tag);
        checks++;
        if (err_pending !== exp) begin
            errors++;
            $display("FAIL %s err_pending actual=%0b expected=%0b", tag, err_pending, exp);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        pend(1'b0, "R1 reset");
        rd(8'h00, 0, "R1 status"); rd(8'h08, 0, "R1 enable"); rd(8'h0C, 0, "R1 attr");
        rd(8'h10, 0, "R1 mcause"); rd(8'h14, 0, "R1 ccause"); rd(8'h18, 0, "R1 ctarget");
        rd(8'h20, 0, "R1 maddr lo"); rd(8'h24, 0, "R1 maddr hi");

        // R2: enable register readback
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h3, "R2 enable readback");

        // Vector walk: R4/R5/R6 on capture, R8 on discard
        for (int i = 0; i < 4; i++) begin
            strobe(VEC[i]);
            pend(1'b1, "R6 pending");
            rd(8'h00, 32'h1, "R6 status");
            rd(8'h0C, VEC[i].x_attr,   VEC[i].cls ? "R5 attr" : "R4 attr");
            rd(8'h18, VEC[i].x_ctgt,   VEC[i].cls ? "R5 ctarget" : "R4 ctarget");
            rd(8'h14, VEC[i].x_ccause, VEC[i].cls ? "R5 ccause" : "R4 ccause");
            rd(8'h20, VEC[i].x_mlo,    VEC[i].cls ? "R5 maddr lo" : "R4 maddr lo");
            rd(8'h24, VEC[i].x_mhi,    VEC[i].cls ? "R5 maddr hi" : "R4 maddr hi");
            rd(8'h10, VEC[i].x_mcause, VEC[i].cls ? "R5 mcause" : "R4 mcause");
            wr(8'h04, 32'h1);
            pend(1'b0, "R8 discard");
            rd(8'h0C, 32'h0, "R8 attr cleared");
        end

        // R7: second strobe while held
        strobe(VEC[0]);
        strobe(VEC[1]);
        rd(8'h0C, 32'h0F01, "R7 attr held");
        rd(8'h20, 32'h0, "R7 maddr held");

        // R11: writes to record offsets
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0);
        rd(8'h0C, 32'h0F01, "R11 attr");
        rd(8'h20, 32'h0, "R11 maddr lo");
        pend(1'b1, "R11 pending");

        // R8: discard write with bit 0 clear
        wr(8'h04, 32'h2);
        pend(1'b1, "R8 bit0 clear");

        // R9: discard and strobe in one cycle
        clr_and_strobe(VEC[1]);
        pend(1'b1, "R9 pending");
        rd(8'h0C, 32'hF016, "R9 attr new");
        rd(8'h18, 32'h0, "R9 ctarget new");
        rd(8'h24, 32'h12, "R9 maddr hi new");
        wr(8'h04, 32'h1);

        // R3: disabled classes
        wr(8'h08, 32'h1);
        strobe(VEC[1]);
        pend(1'b0, "R3 mem disabled");
        rd(8'h0C, 32'h0, "R3 attr");
        wr(8'h08, 32'h2);
        strobe(VEC[0]);
        pend(1'b0, "R3 cfg disabled");
        strobe(VEC[3]);
        pend(1'b1, "R2 mem enabled only");
        rd(8'h0C, 32'h0102, "R2 attr");
        wr(8'h04, 32'h1);

        // R10: unmapped offsets
        rd(8'h1C, 0, "R10 hole"); rd(8'h28, 0, "R10 above"); rd(8'hFC, 0, "R10 top");
        rd(8'h01, 0, "R10 unaligned"); rd(8'h04, 0, "R10 discard");

        // R1: reset while a record is held
        strobe(VEC[3]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pend(1'b0, "R1 reset held");
        rd(8'h0C, 0, "R1 attr after reset");
        rd(8'h08, 0, "R1 enable after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule